// File: doc/BRIEF.md
# Masked condition field logic unit

This unit holds a 32-bit condition register organised as eight 4-bit fields. It executes two field-combining operations decoded from a 32-bit instruction word. The ternary-immediate operation merges three fields bit by bit through an 8-entry truth table carried in the instruction. The dynamic binary operation merges two fields through a 4-entry truth table read from a third field. In both operations the destination field is one of the inputs, so each operation is a read-modify-write of that field.

A 4-bit write mask in the instruction picks which destination bits take the new value. The other bits keep their old value. A recognised operation with an all-zero mask writes nothing and raises a one-cycle illegal-instruction flag. The unit accepts one instruction per cycle while `issue` is high. The result is visible on `cr_q` after the clock edge that samples the instruction.

Top module: `cond_field_logic_unit`

## Requirements
- R1: While `rst_n` is low, `cr_q` is set to the reset value (all zeros by default) and `illegal` is 0.
- R2: Field n (0..7) is `cr_q[31-4n -: 4]`. Field bit 0 is the most significant bit of that nibble (`cr_q[31-4n]`), and field bit 3 is `cr_q[28-4n]`.
- R3: Instruction bits are numbered from the most significant, so bit k is `insn[31-k]`, and each multi-bit field is read most significant bit first. Bits 0-5 must equal 19, or nothing happens. Bits 26-30 select the operation: 4 means ternary, 6 means binary, and any other value has no effect and raises no flag. The destination field is in bits 6-8, source A in bits 11-13, and source B in bits 16-18.
- R4: Ternary: for each field bit i, j = 4*D[i] + 2*A[i] + B[i], where D is the destination field. The new bit is table bit j. Table bit j (j = 0..6) is instruction bit 19+j, and table bit 7 is instruction bit 31.
- R5: Binary: for each field bit i, j = 2*D[i] + A[i], and the new bit is field-B bit j. Instruction bits 19-25 and 31 are ignored.
- R6: Mask bit i (i = 0..3) is instruction bit 9, 10, 14 and 15 respectively, and it gates field bit i. A destination bit whose mask bit is 0 keeps its value.
- R7: A recognised operation with a mask of 0000 leaves `cr_q` completely unchanged. `illegal` is 1 for exactly the one cycle after the sampling edge.
- R8: All sources are read before the write. The destination may be the same field as A or B, and the result uses the old values.
- R9: Fields other than the destination never change.
- R10: While `issue` is low, `cr_q` holds and `illegal` is 0, whatever `insn` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| issue | input | 1 | Instruction valid this cycle |
| insn | input | 32 | Instruction word |
| cr_q | output | 32 | Condition register contents |
| illegal | output | 1 | Zero-mask trap, one-cycle pulse |

## Verification
The embedded assertions check several properties on every clock:
- Non-destination fields and unmasked bits hold their value.
- Idle cycles and trap cycles leave the register frozen.
- Every `illegal` pulse traces back to a recognised zero-mask instruction.
- An all-ones or all-zeros ternary table drives the masked bits to that constant.

The per-bit table indexing for intermediate tables, the lookup order of the binary table, the aliasing of the destination with a source, and the field and bit numbering can only be shown by the bench. It compares the register against its own model after every clock and adds directed cases with hand-computed register values.

// File: rtl/cfl_pkg.sv
package cfl_pkg;

  localparam int FIELD_W  = 4;
  localparam int N_FIELDS = 8;
  localparam int SEL_W    = $clog2(N_FIELDS);
  localparam int CR_W     = FIELD_W * N_FIELDS;
  localparam int TBL_W    = 1 << 3;
  localparam int LUT2_W   = 1 << 2;
  localparam int XO_W     = 5;
  localparam int PO_W     = 6;
  localparam int INSN_W   = 32;

  typedef enum logic [1:0] {
    CFL_NOP  = 2'd0,
    CFL_TERN = 2'd1,
    CFL_BIN  = 2'd2
  } cfl_mode_e;

  typedef struct packed {
    cfl_mode_e          mode;
    logic [SEL_W-1:0]   dst;
    logic [SEL_W-1:0]   fa;
    logic [SEL_W-1:0]   fb;
    logic [FIELD_W-1:0] mask;   // nibble-aligned: [3] gates field bit 0
    logic [TBL_W-1:0]   tbl;    // tbl[j] is table entry j
  } cfl_op_t;

  // Instruction bit k counted from the most significant end.
  function automatic logic insn_bit(input logic [INSN_W-1:0] w, input int k);
    return w[INSN_W-1-k];
  endfunction

  // Read field n of the condition register as a nibble.
  function automatic logic [FIELD_W-1:0] get_field(input logic [CR_W-1:0] cr,
                                                   input logic [SEL_W-1:0] n);
    return cr[CR_W-1-FIELD_W*int'(n) -: FIELD_W];
  endfunction

  // Three-input lookup: index = {d, a, b}.
  function automatic logic lut3(input logic [TBL_W-1:0] tbl,
                                input logic d, input logic a, input logic b);
    return tbl[{d, a, b}];
  endfunction

  // Two-input lookup: index = {d, a}.
  function automatic logic lut2(input logic [LUT2_W-1:0] lut,
                                input logic d, input logic a);
    return lut[{d, a}];
  endfunction

  // Merge new data into an old nibble under a mask.
  function automatic logic [FIELD_W-1:0] merge_nib(input logic [FIELD_W-1:0] old_v,
                                                   input logic [FIELD_W-1:0] new_v,
                                                   input logic [FIELD_W-1:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction

endpackage

// File: rtl/cfl_decode.sv
module cfl_decode
  import cfl_pkg::*;
#(
  parameter logic [PO_W-1:0] PO_VAL  = 6'd19,
  parameter logic [XO_W-1:0] XO_TERN = 5'd4,
  parameter logic [XO_W-1:0] XO_BIN  = 5'd6
) (
  input  logic [INSN_W-1:0] insn,
  output cfl_op_t           op
);

  localparam int PO_POS   = 0;
  localparam int DST_POS  = 6;
  localparam int FA_POS   = 11;
  localparam int FB_POS   = 16;
  localparam int XO_POS   = 26;
  localparam int TBL_POS  = 19;
  localparam int TBL_LAST = 31;

  logic [PO_W-1:0] po;
  logic [XO_W-1:0] xo;

  // Mask bit positions: two before source A, two after it.
  function automatic int mask_pos(input int i);
    return (i < 2) ? (9 + i) : (12 + i);
  endfunction

  // Table entry positions: seven contiguous, the last in the final bit.
  function automatic int tbl_pos(input int j);
    return (j < TBL_W - 1) ? (TBL_POS + j) : TBL_LAST;
  endfunction

  always_comb begin
    po = '0;
    xo = '0;
    op = '0;
    for (int k = 0; k < PO_W; k++)  po[PO_W-1-k]  = insn_bit(insn, PO_POS + k);
    for (int k = 0; k < XO_W; k++)  xo[XO_W-1-k]  = insn_bit(insn, XO_POS + k);
    for (int k = 0; k < SEL_W; k++) begin
      op.dst[SEL_W-1-k] = insn_bit(insn, DST_POS + k);
      op.fa[SEL_W-1-k]  = insn_bit(insn, FA_POS + k);
      op.fb[SEL_W-1-k]  = insn_bit(insn, FB_POS + k);
    end
    for (int i = 0; i < FIELD_W; i++) op.mask[FIELD_W-1-i] = insn_bit(insn, mask_pos(i));
    for (int j = 0; j < TBL_W; j++)   op.tbl[j] = insn_bit(insn, tbl_pos(j));
    if (po != PO_VAL)        op.mode = CFL_NOP;
    else if (xo == XO_TERN)  op.mode = CFL_TERN;
    else if (xo == XO_BIN)   op.mode = CFL_BIN;
    else                     op.mode = CFL_NOP;
  end

endmodule

// File: rtl/cfl_lane_eval.sv
module cfl_lane_eval
  import cfl_pkg::*;
(
  input  cfl_mode_e          mode,
  input  logic [TBL_W-1:0]   tbl,
  input  logic [FIELD_W-1:0] d_nib,
  input  logic [FIELD_W-1:0] a_nib,
  input  logic [FIELD_W-1:0] b_nib,
  output logic [FIELD_W-1:0] res_nib
);

  // Field B viewed as a table: entry j is field bit j (nibble bit 3-j).
  logic [LUT2_W-1:0] b_lut;

  genvar gj;
  generate
    for (gj = 0; gj < LUT2_W; gj++) begin : g_lut
      assign b_lut[gj] = b_nib[FIELD_W-1-gj];
    end
  endgenerate

  genvar gi;
  generate
    for (gi = 0; gi < FIELD_W; gi++) begin : g_lane
      localparam int P = FIELD_W - 1 - gi;
      logic tern_bit;
      logic bin_bit;
      assign tern_bit   = lut3(tbl, d_nib[P], a_nib[P], b_nib[P]);
      assign bin_bit    = lut2(b_lut, d_nib[P], a_nib[P]);
      assign res_nib[P] = (mode == CFL_BIN) ? bin_bit : tern_bit;
    end
  endgenerate

endmodule

// File: rtl/cfl_field_store.sv
module cfl_field_store
  import cfl_pkg::*;
#(
  parameter logic [CR_W-1:0] RESET_CR = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_field,
  input  logic [FIELD_W-1:0] wr_mask,
  input  logic [FIELD_W-1:0] wr_nib,
  output logic [CR_W-1:0]    cr_q
);

  logic [CR_W-1:0]    cr_d;
  logic [FIELD_W-1:0] old_nib;

  assign old_nib = get_field(cr_q, wr_field);

  always_comb begin
    cr_d = cr_q;
    if (wr_en)
      cr_d[CR_W-1-FIELD_W*int'(wr_field) -: FIELD_W] = merge_nib(old_nib, wr_nib, wr_mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cr_q <= RESET_CR;
    else        cr_q <= cr_d;
  end

  genvar gf;
  generate
    for (gf = 0; gf < N_FIELDS; gf++) begin : g_chk
      // R9: a field not addressed by the write holds its value.
      a_r9_field_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_field == SEL_W'(gf)) |=>
          $stable(cr_q[CR_W-1-FIELD_W*gf -: FIELD_W]));
      for (genvar gb = 0; gb < FIELD_W; gb++) begin : g_bit
        // R6: a bit whose mask bit is clear keeps its value.
        a_r6_mask_keep: assert property (@(posedge clk) disable iff (!rst_n)
          (wr_en && !wr_mask[gb]) |=> $stable(cr_q[CR_W-1-FIELD_W*gf-(FIELD_W-1-gb)]));
      end
    end
  endgenerate

endmodule

// File: rtl/cond_field_logic_unit.sv
module cond_field_logic_unit
  import cfl_pkg::*;
#(
  parameter logic [CR_W-1:0] RESET_CR = '0,
  parameter logic [PO_W-1:0] PO_VAL   = 6'd19,
  parameter logic [XO_W-1:0] XO_TERN  = 5'd4,
  parameter logic [XO_W-1:0] XO_BIN   = 5'd6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        issue,
  input  logic [31:0] insn,
  output logic [31:0] cr_q,
  output logic        illegal
);

  cfl_op_t            op;
  logic [FIELD_W-1:0] d_nib, a_nib, b_nib, res_nib;
  logic               op_known;
  logic               mask_zero;
  logic               wr_en;
  logic               trap_ev;
  logic               illegal_q;

  cfl_decode #(.PO_VAL(PO_VAL), .XO_TERN(XO_TERN), .XO_BIN(XO_BIN)) u_decode (
    .insn (insn),
    .op   (op)
  );

  // All sources are read from the current register before the write.
  assign d_nib = get_field(cr_q, op.dst);
  assign a_nib = get_field(cr_q, op.fa);
  assign b_nib = get_field(cr_q, op.fb);

  cfl_lane_eval u_eval (
    .mode    (op.mode),
    .tbl     (op.tbl),
    .d_nib   (d_nib),
    .a_nib   (a_nib),
    .b_nib   (b_nib),
    .res_nib (res_nib)
  );

  // Named events.
  assign op_known  = issue && (op.mode != CFL_NOP);
  assign mask_zero = (op.mask == '0);
  assign wr_en     = op_known && !mask_zero;
  assign trap_ev   = op_known && mask_zero;

  cfl_field_store #(.RESET_CR(RESET_CR)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_field (op.dst),
    .wr_mask  (op.mask),
    .wr_nib   (res_nib),
    .cr_q     (cr_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) illegal_q <= 1'b0;
    else        illegal_q <= trap_ev;
  end

  assign illegal = illegal_q;

  // R7: the trap cycle leaves the register untouched.
  a_r7_trap_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $stable(cr_q));

  // R7: a trap comes only from a recognised operation with an empty mask.
  a_r7_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(illegal) |-> ($past(issue) && $past(op.mode) != CFL_NOP && $past(op.mask) == '0));

  // R10: an idle cycle changes nothing and flags nothing.
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> (!illegal && $stable(cr_q)));

  // R4: a constant table drives every masked destination bit to that constant.
  a_r4_const_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op.mode == CFL_TERN && op.tbl == '1) |=>
      ((get_field(cr_q, $past(op.dst)) & $past(op.mask)) == $past(op.mask)));

  a_r4_const_zeros: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op.mode == CFL_TERN && op.tbl == '0) |=>
      ((get_field(cr_q, $past(op.dst)) & $past(op.mask)) == '0));

endmodule

// File: tb/cond_field_logic_unit_test.sv
module cond_field_logic_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue;
  logic [31:0] insn;
  logic [31:0] cr;
  logic        illegal;

  always #5 clk = ~clk;

  cond_field_logic_unit uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue   (issue),
    .insn    (insn),
    .cr_q    (cr),
    .illegal (illegal)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    run_cmp = 1'b0;
  bit    done = 1'b0;

  logic [31:0] m_cr;
  logic        m_ill;
  logic [31:0] nx_cr;
  logic        nx_ill;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int mpos(input int i);
    if (i == 0) return 9;
    if (i == 1) return 10;
    if (i == 2) return 14;
    return 15;
  endfunction

  function automatic int tpos(input int j);
    if (j == 7) return 31;
    return 19 + j;
  endfunction

  function automatic int getf(input logic [31:0] w, input int pos, input int n);
    int v = 0;
    for (int k = 0; k < n; k++) v = v * 2 + int'(w[31 - pos - k]);
    return v;
  endfunction

  // Build an instruction: msk bit i = mask bit i, tli bit j = table entry j.
  function automatic logic [31:0] mk(input int po, input int xo, input int bf,
                                     input int ba, input int bb, input int msk,
                                     input int tli);
    logic [31:0] w = '0;
    for (int k = 0; k < 6; k++) w[31 - k]        = po[5 - k];
    for (int k = 0; k < 5; k++) w[31 - (26 + k)] = xo[4 - k];
    for (int k = 0; k < 3; k++) begin
      w[31 - (6 + k)]  = bf[2 - k];
      w[31 - (11 + k)] = ba[2 - k];
      w[31 - (16 + k)] = bb[2 - k];
    end
    for (int i = 0; i < 4; i++) w[31 - mpos(i)] = msk[i];
    for (int j = 0; j < 8; j++) w[31 - tpos(j)] = tli[j];
    return w;
  endfunction

  // Behavioural reference: one instruction applied to a register value.
  function automatic void ref_step(input logic [31:0] c, input logic [31:0] w,
                                   output logic [31:0] nc, output logic il);
    int po, xo, bf, ba, bb, any_m;
    nc = c;
    il = 1'b0;
    po = getf(w, 0, 6);
    xo = getf(w, 26, 5);
    bf = getf(w, 6, 3);
    ba = getf(w, 11, 3);
    bb = getf(w, 16, 3);
    if (po != 19 || (xo != 4 && xo != 6)) return;
    any_m = 0;
    for (int i = 0; i < 4; i++) any_m += int'(w[31 - mpos(i)]);
    if (any_m == 0) begin
      il = 1'b1;
      return;
    end
    for (int i = 0; i < 4; i++) begin
      int d, a, b, j;
      logic v;
      d = int'(c[31 - (4 * bf + i)]);
      a = int'(c[31 - (4 * ba + i)]);
      b = int'(c[31 - (4 * bb + i)]);
      if (xo == 4) begin
        j = 4 * d + 2 * a + b;
        v = w[31 - tpos(j)];
      end else begin
        j = 2 * d + a;
        v = c[31 - (4 * bb + j)];
      end
      if (w[31 - mpos(i)]) nc[31 - (4 * bf + i)] = v;
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cr  = '0;
      m_ill = 1'b0;
    end else if (issue) begin
      ref_step(m_cr, insn, nx_cr, nx_ill);
      m_cr  = nx_cr;
      m_ill = nx_ill;
    end else begin
      m_ill = 1'b0;
    end
  end

  // Every-cycle comparison against the model (R2, R9 on every clock).
  always @(negedge clk) begin
    if (run_cmp) begin
      chk(cur_req, "cr (model, R9)", cr, m_cr);
      chk(cur_req, "illegal (model)", {31'd0, illegal}, {31'd0, m_ill});
    end
  end

  // Called at a negedge; returns at the negedge after the sampling edge.
  task automatic do_op(input string req, input logic [31:0] w);
    cur_req = req;
    issue = 1'b1;
    insn  = w;
    @(negedge clk);
    issue = 1'b0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  logic [31:0] lcg;
  logic [31:0] prev;

  initial begin
    rst_n = 1'b0;
    issue = 1'b0;
    insn  = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "cr after reset", cr, 32'h0);
    chk("R1", "illegal after reset", {31'd0, illegal}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run_cmp = 1'b1;

    // R6 / R2: field 3, mask bits 0 and 2, all-ones table
    do_op("R6", mk(19, 4, 3, 0, 0, 4'b0101, 8'hFF));
    chk("R6", "partial mask on field 3", cr, 32'h000A_0000);
    // R2: field 0 bit 0 is the register's top bit
    do_op("R2", mk(19, 4, 0, 0, 0, 4'b0001, 8'hFF));
    chk("R2", "field 0 bit 0 position", cr, 32'h800A_0000);
    // Build field 1 = 1100, field 2 = 1010
    do_op("R4", mk(19, 4, 1, 0, 0, 4'b0011, 8'hFF));
    do_op("R4", mk(19, 4, 2, 0, 0, 4'b0101, 8'hFF));
    chk("R4", "setup fields 1 and 2", cr, 32'h8CAA_0000);
    // R4: OR of fields 1 and 2 into empty field 4
    do_op("R4", mk(19, 4, 4, 1, 2, 4'b1111, 8'h0E));
    chk("R4", "ternary OR into field 4", cr, 32'h8CAA_E000);
    // R5: binary, table from field 2, index from field 1, garbage in table bits
    do_op("R5", mk(19, 6, 5, 1, 2, 4'b1111, 8'hA5));
    chk("R5", "binary lookup into field 5", cr, 32'h8CAA_E300);
    // R6: binary, only mask bit 3
    do_op("R6", mk(19, 6, 6, 1, 0, 4'b1000, 8'h00));
    chk("R6", "binary single mask bit", cr, 32'h8CAA_E310);
    // R8: destination equals source A, XOR with field 2
    do_op("R8", mk(19, 4, 1, 1, 2, 4'b1111, 8'h42));
    chk("R8", "destination aliases source", cr, 32'h86AA_E310);
    // R7: zero mask, ternary
    do_op("R7", mk(19, 4, 2, 0, 0, 4'b0000, 8'hFF));
    chk("R7", "illegal after zero mask", {31'd0, illegal}, 32'd1);
    chk("R7", "cr unchanged on trap", cr, 32'h86AA_E310);
    @(negedge clk);
    chk("R7", "illegal lasts one cycle", {31'd0, illegal}, 32'd0);
    // R7: zero mask, binary
    do_op("R7", mk(19, 6, 3, 1, 2, 4'b0000, 8'h00));
    chk("R7", "binary zero mask traps", {31'd0, illegal}, 32'd1);
    // R3: unknown extended opcode, wrong primary opcode
    do_op("R3", mk(19, 5, 3, 0, 0, 4'b1111, 8'h00));
    chk("R3", "unknown XO no effect", cr, 32'h86AA_E310);
    chk("R3", "unknown XO no trap", {31'd0, illegal}, 32'd0);
    do_op("R3", mk(20, 4, 3, 0, 0, 4'b1111, 8'h00));
    chk("R3", "wrong primary opcode", cr, 32'h86AA_E310);
    do_op("R3", mk(20, 4, 3, 0, 0, 4'b0000, 8'h00));
    chk("R3", "wrong primary opcode no trap", {31'd0, illegal}, 32'd0);
    // R10: valid instruction word held while issue is low
    cur_req = "R10";
    insn = mk(19, 4, 0, 0, 0, 4'b1111, 8'h00);
    repeat (3) @(negedge clk);
    chk("R10", "idle holds cr", cr, 32'h86AA_E310);
    chk("R10", "idle no trap", {31'd0, illegal}, 32'd0);
    // R9: write field 7, all other fields intact
    prev = cr;
    do_op("R9", mk(19, 6, 7, 0, 1, 4'b1111, 8'h00));
    chk("R9", "other fields unchanged", cr & 32'hFFFF_FFF0, prev & 32'hFFFF_FFF0);

    // Mixed sequence, checked by the every-cycle model comparison
    lcg = 32'h1234_5678;
    for (int n = 0; n < 600; n++) begin
      int sel, xo, msk;
      lcg = lcg * 32'd1103515245 + 32'd12345;
      sel = int'(lcg[31:28]);
      msk = int'(lcg[27:24]);
      xo  = (sel < 7) ? 4 : (sel < 13) ? 6 : (sel == 13) ? int'(lcg[4:0]) : 4;
      if (sel == 15) msk = 0;
      if (sel == 14) begin
        cur_req = "R10";
        issue = 1'b0;
        insn  = lcg;
        @(negedge clk);
      end else begin
        do_op((xo == 4) ? "R4" : (xo == 6) ? "R5" : "R3",
              mk(19, xo, int'(lcg[23:21]), int'(lcg[20:18]), int'(lcg[17:15]),
                 msk, int'(lcg[14:7])));
      end
    end
    @(negedge clk);
    run_cmp = 1'b0;
    done = 1'b1;
    summary();
    $finish;
  end

endmodule